// File: doc/BRIEF.md
# Streaming Correlation Sum Engine

This block produces the three running sums from which a normalized correlation coefficient between a reference image and a transformed test image is formed. Both images arrive together, as a stream of wide words that each carry LANES 8-bit pixels. On every accepted word the block subtracts the proper mean from each pixel, forms the cross product and the two squares for every lane, reduces the lanes through a balanced adder tree and adds the result into three signed accumulators. A pass over S pixels therefore costs about S/LANES accepted words.

The reference mean is a constant that the host computes once. The test mean comes from the stage that built the transformed image. Software starts a pass with a pulse that also gives the pixel count. When the last counted pixel has reached the accumulators, a done flag rises. The final square root and division are left to the consumer of the three sums.

Top module: `ncc_corr_accum`

## Requirements
- R1: After reset all three sums read zero and `done` is low.
- R2: Means are unsigned 16-bit values with 8 fractional bits. A pixel p deviates from its mean m by d = p*256 - m, a signed quantity. `sum_rt` accumulates dr*dt, `sum_rr` accumulates dr*dr and `sum_tt` accumulates dt*dt, each as a signed value with 16 fractional bits. A test pixel of zero takes part in the sums as zero.
- R3: Each accepted word carries LANES pixel pairs. Lane i occupies bits [8i+7:8i] of `ref_word` and of `tst_word`, and lane 0 is the earliest pixel in the stream.
- R4: When the pixel count is not a multiple of LANES, only the lowest count-mod-LANES lanes of the final word enter the sums.
- R5: A cycle with `in_valid` low leaves the pass unchanged, and words offered after the counted pixels have all been accepted are ignored.
- R6: Both means are sampled in the start cycle. Changes on the mean inputs later in the pass have no effect.
- R7: `start` clears the sums and `done` on the following edge and loads a new count. The word offered in the start cycle is not accepted, and words of an earlier pass still in flight are discarded.
- R8: `done` rises on the third clock edge after the edge that accepts the final word. It then stays high, with the sums frozen, until the next `start`.
- R9: A pass with a count of zero raises `done` three edges after the start edge, and all sums are zero.
- R10: The accumulators are 64-bit signed and do not overflow for a 1024x1024 image at the most extreme pixel and mean values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass: clear the sums, latch the means and the count |
| pix_count | input | CNT_W (21) | Number of pixel pairs in the pass |
| ref_mean | input | 16 | Reference image mean, 8 fractional bits |
| tst_mean | input | 16 | Test image mean, 8 fractional bits |
| in_valid | input | 1 | The two words on this cycle carry pixels |
| ref_word | input | LANES*8 (64) | Reference pixels, lane 0 in the low byte |
| tst_word | input | LANES*8 (64) | Test pixels, lane 0 in the low byte |
| sum_rt | output | ACC_W (64) | Signed sum of cross deviations |
| sum_rr | output | ACC_W (64) | Signed sum of squared reference deviations |
| sum_tt | output | ACC_W (64) | Signed sum of squared test deviations |
| done | output | 1 | Every counted pixel has reached the sums |

## Verification
The hardest case to reach from the ports is a restart while an earlier pass still has words in the four-stage pipeline. If any of those stale words leaked through, the new sums would be off by only a few products. The bench therefore feeds several words of a pass it never finishes and then issues `start` at once, with a valid word held in the start cycle, and compares the sums against a model that only knows the second pass. Partial final words, gaps in `in_valid`, drifting means and surplus words after the count are mixed into seeded random passes so that lane masking and the hold of sampled state are stressed together.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

    // Flags that travel down the pipeline alongside the lane data.
    typedef struct packed {
        logic vld;   // stage holds an accepted word
        logic last;  // stage closes the pass
    } ncc_tag_t;

    localparam ncc_tag_t NCC_TAG_IDLE = '{vld: 1'b0, last: 1'b0};

endpackage

// File: rtl/ncc_lane.sv
// One lane: mean subtraction (stage 1), then the three products (stage 2).
module ncc_lane #(
    parameter  int PIX_W  = 8,
    parameter  int FRAC   = 8,
    localparam int MEAN_W = PIX_W + FRAC,
    localparam int DEV_W  = MEAN_W + 2,
    localparam int PROD_W = 2 * DEV_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [PIX_W-1:0]         ref_pix,
    input  logic [PIX_W-1:0]         tst_pix,
    input  logic [MEAN_W-1:0]        ref_mean,
    input  logic [MEAN_W-1:0]        tst_mean,
    output logic signed [PROD_W-1:0] prod_rt,
    output logic signed [PROD_W-1:0] prod_rr,
    output logic signed [PROD_W-1:0] prod_tt
);

    typedef struct packed {
        logic signed [DEV_W-1:0]  dr;
        logic signed [DEV_W-1:0]  dt;
        logic signed [PROD_W-1:0] rt;
        logic signed [PROD_W-1:0] rr;
        logic signed [PROD_W-1:0] tt;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A masked lane contributes a zero deviation, hence zero products.
        if (en) begin
            st_d.dr = $signed({2'b00, ref_pix, {FRAC{1'b0}}}) - $signed({2'b00, ref_mean});
            st_d.dt = $signed({2'b00, tst_pix, {FRAC{1'b0}}}) - $signed({2'b00, tst_mean});
        end else begin
            st_d.dr = '0;
            st_d.dt = '0;
        end
        st_d.rt = st_q.dr * st_q.dt;
        st_d.rr = st_q.dr * st_q.dr;
        st_d.tt = st_q.dt * st_q.dt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_rt = st_q.rt;
    assign prod_rr = st_q.rr;
    assign prod_tt = st_q.tt;

endmodule

// File: rtl/ncc_sum_tree.sv
// Balanced binary reduction of N signed leaves, registered at the root.
module ncc_sum_tree #(
    parameter  int N     = 8,
    parameter  int IN_W  = 36,
    localparam int LVL   = (N > 1) ? $clog2(N) : 0,
    localparam int NPAD  = 1 << LVL,
    localparam int OUT_W = IN_W + LVL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  leaf [N],
    output logic signed [OUT_W-1:0] total
);

    typedef struct packed {
        logic signed [OUT_W-1:0] sum;
    } tree_st_t;

    tree_st_t st_d, st_q;

    always_comb begin
        logic signed [OUT_W-1:0] node [2*NPAD-1];
        st_d = st_q;
        // Leaves live at heap positions NPAD-1 .. 2*NPAD-2; padding leaves are zero.
        for (int j = 0; j < NPAD; j++) begin
            if (j < N) node[NPAD-1+j] = OUT_W'(leaf[j]);
            else       node[NPAD-1+j] = '0;
        end
        for (int i = NPAD - 2; i >= 0; i--) begin
            node[i] = node[2*i+1] + node[2*i+2];
        end
        st_d.sum = node[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total = st_q.sum;

endmodule

// File: rtl/ncc_feed_ctrl.sv
// Tracks the pixels still owed to the pass and masks lanes of the last word.
module ncc_feed_ctrl #(
    parameter int LANES = 8,
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pix_count,
    input  logic             in_valid,
    output logic [LANES-1:0] lane_en,
    output logic             take,
    output logic             last
);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } feed_st_t;

    feed_st_t st_d, st_q;
    logic     busy;
    logic     final_word;

    always_comb begin
        busy       = (st_q.rem != '0);
        final_word = (st_q.rem <= CNT_W'(LANES));
        take       = in_valid && !start && busy;
        last       = (take && final_word) || (start && (pix_count == '0));
        for (int i = 0; i < LANES; i++) begin
            lane_en[i] = (st_q.rem > CNT_W'(i));
        end

        st_d = st_q;
        if (start) begin
            st_d.rem = pix_count;
        end else if (take) begin
            st_d.rem = final_word ? '0 : (st_q.rem - CNT_W'(LANES));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ncc_corr_accum.sv
// Top: lanes -> three sum trees -> three accumulators, plus pass control.
module ncc_corr_accum #(
    parameter  int LANES  = 8,
    parameter  int PIX_W  = 8,
    parameter  int FRAC   = 8,
    parameter  int CNT_W  = 21,
    parameter  int ACC_W  = 64,
    localparam int MEAN_W = PIX_W + FRAC,
    localparam int DEV_W  = MEAN_W + 2,
    localparam int PROD_W = 2 * DEV_W,
    localparam int LVL    = (LANES > 1) ? $clog2(LANES) : 0,
    localparam int SUM_W  = PROD_W + LVL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        pix_count,
    input  logic [MEAN_W-1:0]       ref_mean,
    input  logic [MEAN_W-1:0]       tst_mean,
    input  logic                    in_valid,
    input  logic [LANES*PIX_W-1:0]  ref_word,
    input  logic [LANES*PIX_W-1:0]  tst_word,
    output logic signed [ACC_W-1:0] sum_rt,
    output logic signed [ACC_W-1:0] sum_rr,
    output logic signed [ACC_W-1:0] sum_tt,
    output logic                    done
);
    import ncc_pkg::*;

    typedef struct packed {
        logic [MEAN_W-1:0]       mean_r;
        logic [MEAN_W-1:0]       mean_t;
        ncc_tag_t                tag1;   // aligned with lane deviations
        ncc_tag_t                tag2;   // aligned with lane products
        ncc_tag_t                tag3;   // aligned with tree outputs
        logic signed [ACC_W-1:0] acc_rt;
        logic signed [ACC_W-1:0] acc_rr;
        logic signed [ACC_W-1:0] acc_tt;
        logic                    fin;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [LANES-1:0]         lane_en;
    logic                     take;
    logic                     last;
    logic signed [PROD_W-1:0] p_rt [LANES];
    logic signed [PROD_W-1:0] p_rr [LANES];
    logic signed [PROD_W-1:0] p_tt [LANES];
    logic signed [SUM_W-1:0]  t_rt;
    logic signed [SUM_W-1:0]  t_rr;
    logic signed [SUM_W-1:0]  t_tt;

    ncc_feed_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pix_count (pix_count),
        .in_valid  (in_valid),
        .lane_en   (lane_en),
        .take      (take),
        .last      (last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ncc_lane #(.PIX_W(PIX_W), .FRAC(FRAC)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (lane_en[g]),
            .ref_pix  (ref_word[g*PIX_W +: PIX_W]),
            .tst_pix  (tst_word[g*PIX_W +: PIX_W]),
            .ref_mean (st_q.mean_r),
            .tst_mean (st_q.mean_t),
            .prod_rt  (p_rt[g]),
            .prod_rr  (p_rr[g]),
            .prod_tt  (p_tt[g])
        );
    end

    ncc_sum_tree #(.N(LANES), .IN_W(PROD_W)) u_tree_rt (
        .clk(clk), .rst_n(rst_n), .leaf(p_rt), .total(t_rt)
    );
    ncc_sum_tree #(.N(LANES), .IN_W(PROD_W)) u_tree_rr (
        .clk(clk), .rst_n(rst_n), .leaf(p_rr), .total(t_rr)
    );
    ncc_sum_tree #(.N(LANES), .IN_W(PROD_W)) u_tree_tt (
        .clk(clk), .rst_n(rst_n), .leaf(p_tt), .total(t_tt)
    );

    always_comb begin
        st_d = st_q;
        st_d.tag1.vld  = take;
        st_d.tag1.last = last;
        if (start) begin
            st_d.mean_r = ref_mean;
            st_d.mean_t = tst_mean;
            st_d.tag2   = NCC_TAG_IDLE;
            st_d.tag3   = NCC_TAG_IDLE;
            st_d.acc_rt = '0;
            st_d.acc_rr = '0;
            st_d.acc_tt = '0;
            st_d.fin    = 1'b0;
        end else begin
            st_d.tag2 = st_q.tag1;
            st_d.tag3 = st_q.tag2;
            if (st_q.tag3.vld) begin
                st_d.acc_rt = st_q.acc_rt + {{(ACC_W-SUM_W){t_rt[SUM_W-1]}}, t_rt};
                st_d.acc_rr = st_q.acc_rr + {{(ACC_W-SUM_W){t_rr[SUM_W-1]}}, t_rr};
                st_d.acc_tt = st_q.acc_tt + {{(ACC_W-SUM_W){t_tt[SUM_W-1]}}, t_tt};
            end
            if (st_q.tag3.last) st_d.fin = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_rt = st_q.acc_rt;
    assign sum_rr = st_q.acc_rr;
    assign sum_tt = st_q.acc_tt;
    assign done   = st_q.fin;

endmodule

// File: rtl/ncc_corr_accum_chk.sv
module ncc_corr_accum_chk #(
    parameter int CNT_W = 21,
    parameter int ACC_W = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [CNT_W-1:0]        pix_count,
    input logic signed [ACC_W-1:0] sum_rt,
    input logic signed [ACC_W-1:0] sum_rr,
    input logic signed [ACC_W-1:0] sum_tt,
    input logic                    done
);

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sum_rt == '0 && sum_rr == '0 && sum_tt == '0 && !done));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r8_sums_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(sum_rt) && $stable(sum_rr) && $stable(sum_tt)));

    a_r2_squares_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_rr >= 0 && sum_tt >= 0));

    a_r9_empty_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pix_count == '0) |=> (!done && sum_rt == '0));

endmodule

bind ncc_corr_accum ncc_corr_accum_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pix_count (pix_count),
    .sum_rt    (sum_rt),
    .sum_rr    (sum_rr),
    .sum_tt    (sum_tt),
    .done      (done)
);

// File: tb/tb_ncc_corr_accum.sv
module tb_ncc_corr_accum;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int CNT_W = 21;
    localparam int ACC_W = 64;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [CNT_W-1:0]        pix_count = '0;
    logic [15:0]             ref_mean = '0;
    logic [15:0]             tst_mean = '0;
    logic                    in_valid = 1'b0;
    logic [LANES*8-1:0]      ref_word = '0;
    logic [LANES*8-1:0]      tst_word = '0;
    logic signed [ACC_W-1:0] sum_rt;
    logic signed [ACC_W-1:0] sum_rr;
    logic signed [ACC_W-1:0] sum_tt;
    logic                    done;

    int total = 0;
    int bad = 0;
    longint e_rt, e_rr, e_tt;
    int mr_held, mt_held;

    always #(CLK_PERIOD/2) clk = ~clk;

    ncc_corr_accum #(.LANES(LANES), .CNT_W(CNT_W), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_count(pix_count),
        .ref_mean(ref_mean), .tst_mean(tst_mean), .in_valid(in_valid),
        .ref_word(ref_word), .tst_word(tst_word),
        .sum_rt(sum_rt), .sum_rr(sum_rr), .sum_tt(sum_tt), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_sums(input string req);
        check(sum_rt == e_rt, req, "sum_rt", sum_rt, e_rt);
        check(sum_rr == e_rr, req, "sum_rr", sum_rr, e_rr);
        check(sum_tt == e_tt, req, "sum_tt", sum_tt, e_tt);
    endtask

    // Called just after a negedge; returns just after the negedge following start.
    task automatic do_start(input int cnt, input int mr, input int mt);
        start     = 1'b1;
        pix_count = CNT_W'(cnt);
        ref_mean  = 16'(mr);
        tst_mean  = 16'(mt);
        in_valid  = 1'b1;                  // R7: this word must not be accepted
        ref_word  = {$urandom, $urandom};
        tst_word  = {$urandom, $urandom};
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
        mr_held  = mr;
        mt_held  = mt;
        e_rt = 0; e_rr = 0; e_tt = 0;
    endtask

    // mode 0: random pixels, mode 1: extreme values
    task automatic feed(input int cnt, input int mode, input bit gaps,
                        input bit zero_bias, input bit jitter, input int extra);
        int remaining = cnt;
        int lat = 0;
        while (remaining > 0) begin
            if (jitter) begin
                ref_mean = 16'($urandom);
                tst_mean = 16'($urandom);
            end
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                ref_word = {$urandom, $urandom};
                @(negedge clk);
                continue;
            end
            for (int l = 0; l < LANES; l++) begin
                int rp, tp;
                longint dr, dt;
                rp = (mode == 1) ? 255 : int'($urandom % 256);
                tp = (mode == 1) ? 0 : int'($urandom % 256);
                if (zero_bias && ($urandom % 3 == 0)) tp = 0;
                ref_word[l*8 +: 8] = 8'(rp);
                tst_word[l*8 +: 8] = 8'(tp);
                if (l < remaining) begin
                    dr = longint'(rp) * 256 - longint'(mr_held);
                    dt = longint'(tp) * 256 - longint'(mt_held);
                    e_rt += dr * dt;
                    e_rr += dr * dr;
                    e_tt += dt * dt;
                end
            end
            in_valid = 1'b1;
            @(negedge clk);
            remaining -= LANES;
        end
        in_valid = 1'b0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 3, "R8", "done latency after final word", lat, 3);
        for (int k = 0; k < extra; k++) begin
            in_valid = 1'b1;
            ref_word = {$urandom, $urandom};
            tst_word = {$urandom, $urandom};
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(done == 1'b1, "R8", "done still high", done, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sum_rt == 0 && sum_rr == 0 && sum_tt == 0, "R1", "sums in reset", sum_rt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        // R2 R3: full words, random data
        do_start(64, 128 * 256 + 37, 90 * 256 + 200);
        check(done == 1'b0 && sum_rt == 0, "R7", "cleared after start", sum_rt, 0);
        feed(64, 0, 1'b0, 1'b0, 1'b0, 0);
        check_sums("R2");

        // R4 R5: partial final word and gaps
        do_start(61, 3000, 61000);
        feed(61, 0, 1'b1, 1'b0, 1'b0, 0);
        check_sums("R4");

        // R5 R6: zero test pixels, drifting means, surplus words
        do_start(37, 20000, 45000);
        feed(37, 0, 1'b1, 1'b1, 1'b1, 3);
        check_sums("R6");
        check_sums("R5");

        // R7: restart with words of an abandoned pass in flight
        do_start(400, 1000, 2000);
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1;
            ref_word = {$urandom, $urandom};
            tst_word = {$urandom, $urandom};
            @(negedge clk);
        end
        do_start(24, 50000, 7000);
        feed(24, 0, 1'b0, 1'b0, 1'b0, 0);
        check_sums("R7");

        // R9: empty pass
        start = 1'b1; pix_count = '0;
        @(negedge clk);
        start = 1'b0;
        e_rt = 0; e_rr = 0; e_tt = 0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 3, "R9", "done latency for empty pass", lat, 3);
        check_sums("R9");

        // R10: extreme magnitudes
        do_start(512, 0, 65535);
        feed(512, 1, 1'b0, 1'b0, 1'b0, 0);
        check_sums("R10");
        check(sum_rt < 0 && sum_tt > 0, "R10", "sign of extreme sums", sum_rt, e_rt);

        // Random passes mixing all features
        for (int j = 0; j < 20; j++) begin
            int cnt;
            cnt = 1 + int'($urandom % 300);
            do_start(cnt, int'($urandom % 65536), int'($urandom % 65536));
            feed(cnt, 0, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3));
            check_sums("R3");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule